// File: doc/BRIEF.md
# Three-Phase Carrier PWM with Dead-Time Insertion

This block produces the six gate commands for a three-leg bridge. A free-running counter forms a carrier that either ramps up and wraps (edge-aligned) or ramps up then down (center-aligned). Three compare channels are each checked against the carrier. Each channel drives one leg: an upper and a lower gate signal that are complements of each other. A programmable dead time keeps the two switches of a leg from conducting at the same time.

Software-side values reach the block through a small write port. The period, the three compare values and the per-output polarity are staged in shadow registers. They move into the working registers only when the counter is at zero, so a new setting never breaks a carrier period that is already running. The dead time applies as soon as it is written. A one-cycle pulse marks the top of the carrier, and an external reference sequencer uses it to step the next compare values.

Top module: `pwm3_dead_top`

## Requirements
- R1: With `mode_updn`=0 the counter runs 0,1,…,P and then returns to 0, where P is the working period. `period_match` pulses once every P+1 cycles.
- R2: With `mode_updn`=1 the counter runs 0 up to P and back down to 1, then repeats from 0. `period_match` pulses once every 2P cycles.
- R3: A write to the period, to a compare value or to the polarity lands in a shadow register. It takes effect only after the counter next reaches zero while enabled. A period change made in the middle of a period leaves the length of that period unchanged.
- R4: In each leg k, the upper gate (`gate[2k]`) and the lower gate (`gate[2k+1]`) are never active in the same cycle.
- R5: A leg asks for its upper switch while the counter is below its compare value C. Each rising edge of the upper or lower active state is delayed by D cycles, where D is the dead time. Over one period L, the upper gate is active for (C−D) cycles in up mode or (2C−1−D) cycles in up/down mode. The lower gate is active for the rest of L minus D.
- R6: A compare value of 0 keeps the upper gate inactive and the lower gate active for the whole period. A compare value at or above P keeps the upper gate active and the lower gate inactive for the whole period. Neither case produces a rising edge.
- R7: Polarity bit i set to 1 makes `gate[i]` active low; set to 0 makes it active high. The reset value 6'b010101 makes outputs 1, 3 and 5 (`gate[0]`, `gate[2]`, `gate[4]`) active low.
- R8: After reset with `enable` low, every gate is at its inactive-or-idle level, which gives `gate`=6'h3F, and `period_match` is 0. The reset period is 2500, the compare values and the dead time are 0.
- R9: While `enable` is low the counter holds its value, `period_match` stays 0 and the gates stop changing once the dead time has elapsed.
- R10: Write addresses: 0 is the period, 1, 2 and 3 are the compare values of legs 0, 1 and 2, 4 is the dead time (low 8 bits), and 5 is the polarity (low 6 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Lets the counter run |
| mode_updn | input | 1 | 0 = edge-aligned up count, 1 = center-aligned up/down count |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Write data |
| gate | output | 6 | Gate commands; leg k uses bit 2k (upper) and bit 2k+1 (lower) |
| period_match | output | 1 | One-cycle pulse when the counter equals the period |

## Verification
The hardest case to reach from the ports is a shadowed value arriving partway through a running period. The only visible effect is that the current period keeps its old length. The stimulus therefore synchronizes to a `period_match` pulse, waits a few cycles, rewrites the period with a smaller value, and then measures the spacing to the next pulse and to the one after it. The dead-time and duty behaviour is checked from the ports by counting, over exactly one carrier period, the cycles in which each gate is active. These counts are compared with closed-form expectations for directed edge cases and for randomly drawn periods, compare values and dead times.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;
  typedef enum logic {CNT_UP = 1'b0, CNT_UPDN = 1'b1} cnt_mode_e;
  localparam int ADDR_PER  = 0;
  localparam int ADDR_CMP0 = 1;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  pwm3_pkg::cnt_mode_e mode,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic          zero_evt,
  output logic          prd_evt
);
  import pwm3_pkg::*;

  logic dir_up;

  // returns {next direction, next count}
  function automatic logic [CW:0] step(cnt_mode_e m, logic up, logic [CW-1:0] c,
                                       logic [CW-1:0] p);
    logic [CW-1:0] n;
    logic          d;
    if (m == CNT_UP) begin
      d = 1'b1;
      n = (c >= p) ? CW'(0) : c + 1'b1;
    end else if (c == '0) begin
      d = 1'b1;
      n = (p != '0) ? CW'(1) : CW'(0);
    end else if (c >= p) begin
      d = 1'b0;
      n = c - 1'b1;
    end else begin
      d = up;
      n = up ? c + 1'b1 : c - 1'b1;
    end
    return {d, n};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (en) begin
      {dir_up, cnt} <= step(mode, dir_up, cnt, per);
    end
  end

  assign zero_evt = en && (cnt == '0);
  assign prd_evt  = en && (cnt == per);

  // R1: edge-aligned carrier wraps to zero after the top
  p_up_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_evt && mode == CNT_UP) |=> (cnt == '0));

  // R2: center-aligned carrier turns down after a nonzero top
  p_updn_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_evt && mode == CNT_UPDN && per != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R9: counter frozen while disabled
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
endmodule

// File: rtl/pwm_shadow_regs.sv
`timescale 1ns/1ps
module pwm_shadow_regs #(
  parameter int CW      = 16,
  parameter int DW      = 8,
  parameter int NCH     = 3,
  parameter int AW      = 3,
  parameter int RST_PER = 2500
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    load,
  output logic [CW-1:0]           per_act,
  output logic [NCH-1:0][CW-1:0]  cmp_act,
  output logic [2*NCH-1:0]        pol_act,
  output logic [DW-1:0]           dt
);
  import pwm3_pkg::*;

  localparam int NG       = 2 * NCH;
  localparam int ADDR_DT  = ADDR_CMP0 + NCH;
  localparam int ADDR_POL = ADDR_DT + 1;

  // upper outputs of every leg default to active low
  function automatic logic [NG-1:0] upper_low_mask();
    logic [NG-1:0] m;
    for (int i = 0; i < NG; i++) m[i] = (i % 2 == 0);
    return m;
  endfunction
  localparam logic [NG-1:0] POL_RST = upper_low_mask();

  logic [CW-1:0]          per_sh;
  logic [NCH-1:0][CW-1:0] cmp_sh;
  logic [NG-1:0]          pol_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_sh <= CW'(RST_PER);
      cmp_sh <= '0;
      pol_sh <= POL_RST;
      dt     <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) == ADDR_PER) per_sh <= wr_data;
      if (int'(wr_addr) == ADDR_DT)  dt     <= wr_data[DW-1:0];
      if (int'(wr_addr) == ADDR_POL) pol_sh <= wr_data[NG-1:0];
      for (int i = 0; i < NCH; i++)
        if (int'(wr_addr) == ADDR_CMP0 + i) cmp_sh[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act <= CW'(RST_PER);
      cmp_act <= '0;
      pol_act <= POL_RST;
    end else if (load) begin
      per_act <= per_sh;
      cmp_act <= cmp_sh;
      pol_act <= pol_sh;
    end
  end

  // R3: working values move only on the zero event
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(per_act) && $stable(cmp_act) && $stable(pol_act)));
endmodule

// File: rtl/pwm_deadband.sv
`timescale 1ns/1ps
module pwm_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [DW-1:0] dt,
  output logic          hi_on,
  output logic          lo_on
);
  logic          req_q;
  logic [DW-1:0] dcnt;
  logic          settled;

  assign settled = (dcnt >= dt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      dcnt  <= '0;
    end else if (req != req_q) begin
      req_q <= req;
      dcnt  <= '0;
    end else if (!settled) begin
      dcnt <= dcnt + 1'b1;
    end
  end

  assign hi_on = req_q && settled;
  assign lo_on = !req_q && settled;

  // R5: a rising gate never follows the partner directly when a gap is set
  p_gap_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dt != '0 && $rose(hi_on)) |-> !$past(lo_on));
  p_gap_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dt != '0 && $rose(lo_on)) |-> !$past(hi_on));
endmodule

// File: rtl/pwm3_dead_top.sv
`timescale 1ns/1ps
module pwm3_dead_top #(
  parameter int CW         = 16,
  parameter int DW         = 8,
  parameter int NCH        = 3,
  parameter int AW         = 3,
  parameter int RST_PERIOD = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_updn,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [2*NCH-1:0]  gate,
  output logic              period_match
);
  import pwm3_pkg::*;

  localparam int NG = 2 * NCH;

  logic [CW-1:0]          cnt;
  logic                   zero_evt;
  logic                   prd_evt;
  logic [CW-1:0]          per_act;
  logic [NCH-1:0][CW-1:0] cmp_act;
  logic [NG-1:0]          pol_act;
  logic [DW-1:0]          dt;
  logic [NCH-1:0]         leg_req;
  logic [NG-1:0]          gate_on;

  // upper switch requested while below compare; full-on at or above period
  function automatic logic upper_req(logic [CW-1:0] c, logic [CW-1:0] cmp,
                                     logic [CW-1:0] p);
    return (cmp >= p) || (c < cmp);
  endfunction

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(enable),
    .mode(cnt_mode_e'(mode_updn)), .per(per_act),
    .cnt(cnt), .zero_evt(zero_evt), .prd_evt(prd_evt)
  );

  pwm_shadow_regs #(.CW(CW), .DW(DW), .NCH(NCH), .AW(AW), .RST_PER(RST_PERIOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(zero_evt), .per_act(per_act), .cmp_act(cmp_act), .pol_act(pol_act), .dt(dt)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_leg
    assign leg_req[k] = upper_req(cnt, cmp_act[k], per_act);

    pwm_deadband #(.DW(DW)) u_db (
      .clk(clk), .rst_n(rst_n), .req(leg_req[k]), .dt(dt),
      .hi_on(gate_on[2*k]), .lo_on(gate_on[2*k+1])
    );

    // R4: decoded pins of one leg never both active
    p_pair_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !((gate[2*k] ^ pol_act[2*k]) && (gate[2*k+1] ^ pol_act[2*k+1])));
  end

  assign gate         = gate_on ^ pol_act;
  assign period_match = prd_evt;

  // R9: no period pulse while stopped
  p_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !period_match);
endmodule

// File: tb/tb_pwm3_dead_top.sv
`timescale 1ns/1ps
module tb_pwm3_dead_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        mode_updn = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  gate;
  logic        period_match;

  pwm3_dead_top dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_updn(mode_updn),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gate(gate), .period_match(period_match)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [5:0] exp_pol = 6'b010101;
  int hi_n[3], lo_n[3], rise_n[3];
  int excl_bad;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pm();
    do @(negedge clk); while (!period_match);
  endtask

  function automatic int per_len(bit m, int p);
    return m ? 2 * p : p + 1;
  endfunction

  function automatic int exp_hi(bit m, int p, int c, int d);
    if (c == 0) return 0;
    if (c >= p) return per_len(m, p);
    return (m ? 2 * c - 1 : c) - d;
  endfunction

  function automatic int exp_lo(bit m, int p, int c, int d);
    if (c == 0) return per_len(m, p);
    if (c >= p) return 0;
    return per_len(m, p) - (m ? 2 * c - 1 : c) - d;
  endfunction

  task automatic measure(input int len);
    bit prev[3];
    excl_bad = 0;
    for (int k = 0; k < 3; k++) begin
      hi_n[k] = 0; lo_n[k] = 0; rise_n[k] = 0;
      prev[k] = gate[2*k] ^ exp_pol[2*k];
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        bit h, l;
        h = gate[2*k] ^ exp_pol[2*k];
        l = gate[2*k+1] ^ exp_pol[2*k+1];
        if (h && l) excl_bad++;
        if (h) hi_n[k]++;
        if (l) lo_n[k]++;
        if (h && !prev[k]) rise_n[k]++;
        prev[k] = h;
      end
    end
  endtask

  task automatic run_cfg(input bit m, input int p, input int c0, input int c1,
                         input int c2, input int d);
    int cs[3];
    int len, gap;
    cs[0] = c0; cs[1] = c1; cs[2] = c2;
    wr(0, p); wr(1, c0); wr(2, c1); wr(3, c2); wr(4, d);   // R10 map
    @(negedge clk); mode_updn = m;
    repeat (3) wait_pm();
    len = per_len(m, p);
    measure(len);
    check(excl_bad == 0, "R4 pair overlap", excl_bad, 0);
    for (int k = 0; k < 3; k++) begin
      int eh, el;
      eh = exp_hi(m, p, cs[k], d);
      el = exp_lo(m, p, cs[k], d);
      check(hi_n[k] == eh, "R5 upper active cycles", hi_n[k], eh);
      check(lo_n[k] == el, "R5 lower active cycles", lo_n[k], el);
      if (cs[k] == 0 || cs[k] >= p)
        check(rise_n[k] == 0, "R6 no edges at extreme compare", rise_n[k], 0);
    end
    wait_pm();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!period_match);
    if (m) check(gap == len, "R2 up/down period spacing", gap, len);
    else   check(gap == len, "R1 up period spacing", gap, len);
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g0, gap, pm_seen;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(gate == 6'h3F, "R8 reset gate", gate, 6'h3F);
    check(period_match == 1'b0, "R8 reset pulse", period_match, 0);

    // directed: up and up/down with dead time
    enable = 1'b1;
    run_cfg(0, 20, 8, 10, 12, 2);
    run_cfg(1, 20, 8, 10, 12, 2);
    run_cfg(0, 16, 5, 9, 11, 0);
    // R6 extremes: zero, equal to period, above period
    run_cfg(0, 18, 0, 18, 25, 3);
    run_cfg(1, 18, 0, 18, 25, 3);

    // R3 shadowed period: mid-period rewrite leaves current period intact
    run_cfg(0, 20, 6, 8, 10, 1);
    wait_pm();
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'd10;
    @(negedge clk);
    wr_en = 1'b0;
    gap = 6;
    while (!period_match) begin @(negedge clk); gap++; end
    check(gap == 21, "R3 current period kept", gap, 21);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!period_match);
    check(gap == 11, "R3 new period after zero", gap, 11);

    // R7 polarity: all active high
    wr(5, 0);
    repeat (3) wait_pm();
    exp_pol = 6'b000000;
    run_cfg(0, 16, 0, 6, 9, 1);
    @(negedge clk);
    check(gate[1:0] == 2'b10, "R7 active-high pins", gate[1:0], 2);
    wr(5, 6'b010101);
    repeat (3) wait_pm();
    exp_pol = 6'b010101;
    @(negedge clk);
    check(gate[1:0] == 2'b11, "R7 upper active-low pin", gate[1:0], 3);

    // R9 enable low freezes outputs
    @(negedge clk); enable = 1'b0;
    repeat (10) @(negedge clk);
    g0 = gate; pm_seen = 0; gap = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (gate != g0[5:0]) gap++;
      if (period_match) pm_seen++;
    end
    check(gap == 0, "R9 gates frozen", gap, 0);
    check(pm_seen == 0, "R9 no pulse while stopped", pm_seen, 0);
    @(negedge clk); enable = 1'b1;

    // constrained random configurations
    for (int t = 0; t < 8; t++) begin
      int p, d;
      bit m;
      p = 10 + int'($urandom_range(30));
      d = int'($urandom_range(3));
      m = 1'($urandom_range(1));
      run_cfg(m, p, 4 + int'($urandom_range(p - 8)), 4 + int'($urandom_range(p - 8)),
              4 + int'($urandom_range(p - 8)), d);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule